// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer controlled through a single 32-bit control word. Software loads a tick count and a start/stop command. Once the watchdog is armed, it will only take a new control word whose 7-bit key is the bitwise inverse of the key already held. A stray write, or a runaway loop that keeps writing the same value, therefore cannot keep the watchdog alive.

The countdown advances on a slow tick enable supplied from outside, nominally about 760 per second. The first time the count runs out, the watchdog raises a non-maskable interrupt and starts a short grace count. If the grace count also runs out before a valid refresh arrives, the watchdog emits a one-cycle system reset request. A status word gives the current count and the escalation stage.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, `nmiOut` is 0, `resetReqOut` is 0 and the watchdog is stopped.
- R2: A write to address 0x40 carries the count in bits [7:0], the command in bit 8 and the key in bits [15:9]. Reading 0x40 returns the last accepted control word.
- R3: While the stored command bit is 1, a write to 0x40 is ignored unless its bits [15:9] equal the bitwise inverse of the stored bits [15:9]. An ignored write leaves the control word, the count, the stage and `nmiOut` unchanged.
- R4: An accepted write loads the counter from bits [7:0], and a count field of 0 loads 256.
- R5: After an accepted write, a command bit of 1 makes each cycle with `tickEn` high decrement the count by one. A command bit of 0 stops the watchdog, and its count then holds through ticks.
- R6: When a tick arrives while the count is 1 in stage 0, the next cycle shows `nmiOut` at 1, stage 1 and the count reloaded with GRACE_TICKS (default 10).
- R7: When a tick arrives while the count is 1 in stage 1, `resetReqOut` is high for exactly one cycle. After that tick the stage is 2, the count is 0 and further ticks change nothing. `nmiOut` stays high.
- R8: An accepted write sets `nmiOut` to 0 and the stage to 0.
- R9: Reading 0x44 returns the count in bits [8:0] and the stage in bits [17:16], with all other bits 0. Reading any address other than 0x40 or 0x44 returns 0.
- R10: An accepted write that arrives in the same cycle as a tick takes precedence, and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow countdown tick enable, one cycle wide |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data |
| nmiOut | output | 1 | Non-maskable interrupt level |
| resetReqOut | output | 1 | One-cycle system reset request |

## Verification
The assertions take three things for granted about the inputs. `tickEn` and `regWrEn` are sampled only on rising clock edges. The address is stable in any cycle that has a write. GRACE_TICKS is at least 2, so a reload is never mistaken for a final tick. The bench changes every input on the falling edge and holds each write for exactly one cycle. It always leaves the grace parameter at its default, so the stimulus stays inside these conditions.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Field positions in the control word (decoded by the control unit)
  localparam int CNT_FIELD_W = 8;
  localparam int CMD_BIT     = 8;
  localparam int KEY_LSB     = 9;
  localparam int KEY_W       = 7;
  localparam int KEY_MSB     = KEY_LSB + KEY_W - 1;

  typedef enum logic [1:0] {
    STAGE_COUNT   = 2'd0,
    STAGE_GRACE   = 2'd1,
    STAGE_TRIPPED = 2'd2
  } stage_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic load;   // load from control word count field
    logic dec;    // decrement by one
    logic grace;  // reload grace count
    logic clear;  // force to zero
  } cntStrobes_t;

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int GRACE_TICKS = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cntStrobes_t            strobes,
  input  logic [CNT_FIELD_W-1:0] loadField,
  output logic [CNT_W-1:0]       countQ,
  output logic                   lastTick
);

  localparam logic [CNT_W-1:0] ZERO_LOAD  = CNT_W'(1 << CNT_FIELD_W);
  localparam logic [CNT_W-1:0] GRACE_LOAD = CNT_W'(GRACE_TICKS);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] loadValue;

  always_comb begin
    if (loadField == '0) loadValue = ZERO_LOAD;
    else                 loadValue = CNT_W'(loadField);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              countQ <= '0;
    else if (strobes.load)  countQ <= loadValue;
    else if (strobes.clear) countQ <= '0;
    else if (strobes.grace) countQ <= GRACE_LOAD;
    else if (strobes.dec)   countQ <= countQ - ONE;
  end

  assign lastTick = (countQ == ONE);

  // R4: a zero field is taken as the full 256-tick period
  p_zero_means_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load && (loadField == '0) |=> countQ == ZERO_LOAD);

  // R5: a decrement removes exactly one tick
  p_dec_one_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dec |=> countQ == $past(countQ) - ONE);

  // R6: grace reload lands on the parameter value
  p_grace_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.grace && !strobes.load |=> countQ == GRACE_LOAD);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              tickEn,
  input  logic              lastTick,
  output cntStrobes_t       strobes,
  output logic [31:0]       ctrlQ,
  output stage_e            stageQ,
  output logic              runningQ,
  output logic              nmiQ,
  output logic              resetReqQ
);

  logic [KEY_W-1:0] storedKey;
  logic [KEY_W-1:0] newKey;
  logic             armed;
  logic             keyOk;
  logic             accept;
  logic             tickAct;
  logic             expire;

  assign storedKey = ctrlQ[KEY_MSB:KEY_LSB];
  assign newKey    = wrData[KEY_MSB:KEY_LSB];
  assign armed     = ctrlQ[CMD_BIT];
  assign keyOk     = !armed || (newKey == ~storedKey);
  assign accept    = wrEn && (wrAddr == CTRL_OFFSET) && keyOk;
  assign tickAct   = runningQ && tickEn && !accept;
  assign expire    = tickAct && lastTick;

  always_comb begin
    strobes       = '0;
    strobes.load  = accept;
    strobes.dec   = tickAct && !lastTick;
    strobes.grace = expire && (stageQ == STAGE_COUNT);
    strobes.clear = expire && (stageQ == STAGE_GRACE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      stageQ    <= STAGE_COUNT;
      runningQ  <= 1'b0;
      nmiQ      <= 1'b0;
      resetReqQ <= 1'b0;
    end else begin
      resetReqQ <= 1'b0;
      if (accept) begin
        ctrlQ    <= wrData;
        runningQ <= wrData[CMD_BIT];
        stageQ   <= STAGE_COUNT;
        nmiQ     <= 1'b0;
      end else if (expire) begin
        if (stageQ == STAGE_COUNT) begin
          stageQ <= STAGE_GRACE;
          nmiQ   <= 1'b1;
        end else begin
          stageQ    <= STAGE_TRIPPED;
          runningQ  <= 1'b0;
          resetReqQ <= 1'b1;
        end
      end
    end
  end

  // R3: a write with the wrong key while armed leaves the word alone
  p_key_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrAddr == CTRL_OFFSET) && armed && (newKey != ~storedKey)
    |=> $stable(ctrlQ));

  // R8: an accepted write clears the escalation
  p_refresh_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !nmiQ && (stageQ == STAGE_COUNT));

  // R6: the interrupt rises only on the step into the grace stage
  p_nmi_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiQ) |-> (stageQ == STAGE_GRACE) && ($past(stageQ) == STAGE_COUNT));

  // R7: the reset request is a single-cycle pulse
  p_reset_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |=> !resetReqQ);

  // R7: a reset request is always preceded by the interrupt
  p_reset_after_nmi_r7: assert property (@(posedge clk) disable iff (!rstN)
    resetReqQ |-> nmiQ && (stageQ == STAGE_TRIPPED));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 8'h44,
  parameter int                GRACE_TICKS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              nmiOut,
  output logic              resetReqOut
);

  localparam int CNT_W     = CNT_FIELD_W + 1;
  localparam int STAGE_LSB = 16;

  cntStrobes_t      strobes;
  logic [31:0]      ctrlQ;
  stage_e           stageQ;
  logic             runningQ;
  logic [CNT_W-1:0] countQ;
  logic             lastTick;

  wdog_ctrl #(
    .ADDR_W     (ADDR_W),
    .CTRL_OFFSET(CTRL_OFFSET)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrAddr   (regAddr),
    .wrData   (regWrData),
    .tickEn   (tickEn),
    .lastTick (lastTick),
    .strobes  (strobes),
    .ctrlQ    (ctrlQ),
    .stageQ   (stageQ),
    .runningQ (runningQ),
    .nmiQ     (nmiOut),
    .resetReqQ(resetReqOut)
  );

  wdog_counter #(
    .CNT_W      (CNT_W),
    .GRACE_TICKS(GRACE_TICKS)
  ) counter_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadField(regWrData[CNT_FIELD_W-1:0]),
    .countQ   (countQ),
    .lastTick (lastTick)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_OFFSET) begin
      regRdData = ctrlQ;
    end else if (regAddr == STAT_OFFSET) begin
      regRdData[CNT_W-1:0]             = countQ;
      regRdData[STAGE_LSB+1:STAGE_LSB] = stageQ;
    end
  end

  // R5: a stopped watchdog keeps its count when no write arrives
  p_stopped_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    !runningQ && !regWrEn |=> $stable(countQ));

  // R7: once tripped with no write, the count stays at zero
  p_tripped_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stageQ == STAGE_TRIPPED) && !regWrEn |=> countQ == '0);

endmodule

// File: tb/wdog_keyed_tb_top.sv
module wdog_keyed_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [7:0]  A_CTRL     = 8'h40;
  localparam logic [7:0]  A_STAT     = 8'h44;
  localparam int          NVEC       = 12;

  typedef struct packed {
    logic        isTick;
    logic [31:0] arg;
    logic [8:0]  expCount;
    logic [1:0]  expStage;
    logic        expNmi;
  } vec_t;

  // Fields: write word = key[15:9] | cmd[8] | count[7:0]
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0000_2B05, 9'd5,   2'd0, 1'b0}, // R2,R4 key 15 start cnt 5
    '{1'b1, 32'd2,         9'd3,   2'd0, 1'b0}, // R5 two ticks
    '{1'b0, 32'h0000_2B14, 9'd3,   2'd0, 1'b0}, // R3 same key ignored
    '{1'b0, 32'h0000_D500, 9'd256, 2'd0, 1'b0}, // R3,R4 inverse key, 0 -> 256
    '{1'b1, 32'd3,         9'd253, 2'd0, 1'b0}, // R5
    '{1'b0, 32'h0000_2A07, 9'd7,   2'd0, 1'b0}, // R5 stop, cnt 7
    '{1'b1, 32'd4,         9'd7,   2'd0, 1'b0}, // R5 held while stopped
    '{1'b0, 32'h0000_0102, 9'd2,   2'd0, 1'b0}, // R3 disarmed: any key
    '{1'b1, 32'd1,         9'd1,   2'd0, 1'b0}, // R5
    '{1'b1, 32'd1,         9'd10,  2'd1, 1'b1}, // R6 first expiry
    '{1'b1, 32'd9,         9'd1,   2'd1, 1'b1}, // R6 grace counting
    '{1'b0, 32'h0000_FF03, 9'd3,   2'd0, 1'b0}  // R8 refresh clears
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = A_CTRL;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        nmiOut;
  logic        resetReqOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .nmiOut     (nmiOut),
    .resetReqOut(resetReqOut)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic withTick);
    regAddr   = A_CTRL;
    regWrData = d;
    regWrEn   = 1'b1;
    tickEn    = withTick;
    @(negedge clk);
    regWrEn   = 1'b0;
    tickEn    = 1'b0;
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] statWord(input logic [8:0] c, input logic [1:0] s);
    return {14'd0, s, 7'd0, c};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(A_CTRL, rd); checkEq("R1 ctrl after reset", rd, 32'h0);
    readReg(A_STAT, rd); checkEq("R1 status after reset", rd, 32'h0);
    checkEq("R1 nmi after reset", {31'd0, nmiOut}, 32'd0);
    checkEq("R1 resetReq after reset", {31'd0, resetReqOut}, 32'd0);
    doTicks(3);
    readReg(A_STAT, rd); checkEq("R1 stopped after reset", rd, 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].isTick) doTicks(int'(VECS[v].arg));
      else                doWrite(VECS[v].arg, 1'b0);
      readReg(A_STAT, rd);
      checkEq($sformatf("R3,R4,R5,R6,R8 status vector %0d", v), rd,
              statWord(VECS[v].expCount, VECS[v].expStage));
      checkEq($sformatf("R6,R8 nmi vector %0d", v), {31'd0, nmiOut},
              {31'd0, VECS[v].expNmi});
    end

    // R2 readback of last accepted word
    readReg(A_CTRL, rd); checkEq("R2 ctrl readback", rd, 32'h0000_FF03);
    // R9 unmapped address
    readReg(8'h48, rd); checkEq("R9 unmapped read", rd, 32'h0);

    // R3 wrong key while armed with stored key 7F
    doWrite(32'h0000_FF09, 1'b0);
    readReg(A_CTRL, rd); checkEq("R3 rejected ctrl", rd, 32'h0000_FF03);
    readReg(A_STAT, rd); checkEq("R3 rejected count", rd, statWord(9'd3, 2'd0));

    // R6 then R7 full escalation
    doTicks(3);
    checkEq("R6 nmi on first expiry", {31'd0, nmiOut}, 32'd1);
    doTicks(9);
    readReg(A_STAT, rd); checkEq("R6 grace at one", rd, statWord(9'd1, 2'd1));
    checkEq("R7 no request before final tick", {31'd0, resetReqOut}, 32'd0);
    doTicks(1);
    checkEq("R7 reset request pulse", {31'd0, resetReqOut}, 32'd1);
    readReg(A_STAT, rd); checkEq("R7 tripped status", rd, statWord(9'd0, 2'd2));
    @(negedge clk);
    checkEq("R7 reset request one cycle", {31'd0, resetReqOut}, 32'd0);
    doTicks(5);
    readReg(A_STAT, rd); checkEq("R7 tripped holds", rd, statWord(9'd0, 2'd2));
    checkEq("R7 nmi stays", {31'd0, nmiOut}, 32'd1);
    checkEq("R7 no second request", {31'd0, resetReqOut}, 32'd0);

    // R10 write with a simultaneous tick; key inverse of 7F is 00
    doWrite(32'h0000_0104, 1'b1);
    readReg(A_STAT, rd); checkEq("R10 write beats tick", rd, statWord(9'd4, 2'd0));
    checkEq("R8 nmi cleared by refresh", {31'd0, nmiOut}, 32'd0);

    // R1 reset mid-run clears everything
    doTicks(3);
    checkEq("R6 nmi before reset", {31'd0, nmiOut}, 32'd0);
    doTicks(1);
    checkEq("R6 nmi set before reset", {31'd0, nmiOut}, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readReg(A_CTRL, rd); checkEq("R1 ctrl after mid reset", rd, 32'h0);
    readReg(A_STAT, rd); checkEq("R1 status after mid reset", rd, 32'h0);
    checkEq("R1 nmi after mid reset", {31'd0, nmiOut}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule